// File: doc/BRIEF.md
# Capture compare PWM peripheral

This block is a timer companion peripheral built around one 16-bit data register, which software reaches as two bytes. A 4-bit mode field in a control register picks one function at a time. In capture modes the block copies a free-running 16-bit timer value into the data register when the input pin shows a chosen edge, either on every such edge or on every 4th or 16th rising edge. In compare modes it watches for that timer to equal the data register. On a match it can drive the output pin high or low, raise only the interrupt flag, or also fire a one-cycle event that resets the wide timer and starts an A/D conversion.

In PWM modes the block makes a 10-bit-resolution waveform against an external 8-bit period timer. It extends that timer with a 2-bit fine count of its own. The upper eight duty bits come from the low data byte and the lowest two from the control register. A new duty value is only picked up when the period timer wraps to zero. The timers and the converter are outside the block, which only sees their counts and drives their pulses.

Top module: `ccp_unit`

## Requirements
- R1: Any mode whose top two bits are 00 (0000 through 0011) disables the block: the output pin is low, the capture edge divider and the compare output latch are cleared, and neither the flag nor the event pulses are raised.
- R2: Mode 0101 captures on every rising edge and mode 0100 on every falling edge of the input pin. The pin passes through two synchronizing flops, so the timer value is loaded into the data register, and the flag set, at the second clock edge after the first edge that samples the new pin level. Edges of the other polarity capture nothing.
- R3: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Any write that changes the mode field restarts the edge count from zero.
- R4: Mode 1000 sets the output latch and mode 1001 clears it at the clock edge that ends a cycle in which the wide timer equals the data register. Both set the flag at that same edge.
- R5: Mode 1010 sets only the flag on a match and leaves the output pin at its previous level.
- R6: Mode 1011 sets the flag on a match, leaves the pin unchanged, and drives the timer-reset and converter-start outputs high for exactly one cycle after the first cycle of a match.
- R7: Modes 11xx produce PWM. The duty is {low data byte, control bits 5:4}, ten bits. The count is {period timer, 2-bit fine count}, where the fine count is 0 in a cycle in which the period timer differs from its value in the previous cycle and otherwise increments, saturating at 3. The pin is high while the count is below the duty in effect. A duty of 0 keeps it low for the whole period.
- R8: The PWM duty in effect is reloaded only in a cycle in which the period timer reads 0 after a nonzero value. After disable it is 0 until the first such wrap.
- R9: Register addresses: 0 is the low data byte, 1 the high data byte, 2 the control register (bits 3:0 mode, bits 5:4 low duty bits), 3 the flag in bit 0. Control bits 7:6 read as 0, and every register reads 0 after reset.
- R10: The flag is sticky. Any write to address 3 clears it, and a set in the same cycle wins.
- R11: Outside the compare and PWM modes the output pin is low. The timer-reset and converter-start pulses come only from mode 1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register, combinational |
| tmrWide | input | 16 | Free-running wide timer count |
| tmrNarrow | input | 8 | PWM period timer count |
| pinIn | input | 1 | Asynchronous capture input |
| pinOut | output | 1 | Compare or PWM output |
| intFlag | output | 1 | Sticky interrupt flag |
| tmrResetPulse | output | 1 | One-cycle request to reset the wide timer |
| adcStartPulse | output | 1 | One-cycle request to start a conversion |

## Verification
The embedded properties take for granted that the pin holds each level for at least two clocks. A shorter pulse can slip between samples, so an edge or its count may be missed. They also assume the period timer only moves between values that the fine count can extend, and that software does not write a data byte in the cycle that a capture loads it. The stimulus holds every pin level for three clocks and keeps the wide timer steady around each expected capture. It steps the period timer once every four clocks over a ten-value period that wraps to zero, and it places duty writes in mid-period. Random timer and data values in compare tests are drawn so that they miss the data register until a directed match.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  localparam int FINE_BITS = 2;
  localparam int MODE_W = 4;
  localparam int PRESCALE_MID = 4;
  localparam int PRESCALE_HIGH = 16;

  localparam logic [1:0] ADDR_LO = 2'd0;
  localparam logic [1:0] ADDR_HI = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  typedef enum logic [1:0] {
    CAPDIV_EACH = 2'd0,
    CAPDIV_MID = 2'd1,
    CAPDIV_HIGH = 2'd2
  } capDiv_e;

  typedef enum logic [1:0] {
    ACT_SET = 2'd0,
    ACT_CLR = 2'd1,
    ACT_FLAG = 2'd2,
    ACT_EVENT = 2'd3
  } cmpAct_e;

  typedef struct packed {
    logic off;
    logic capOn;
    logic capFall;
    capDiv_e capDiv;
    logic cmpOn;
    cmpAct_e cmpAct;
    logic pwmOn;
    logic modeChg;
  } ctrlStrb_t;
endpackage

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
  import ccp_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int FW = FINE_BITS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [1:0]      regAddr,
  input  logic [BW-1:0]   regWrData,
  output logic [BW-1:0]   regRdData,
  input  logic            capStrobe,
  input  logic [2*BW-1:0] capValue,
  input  logic            flagSet,
  output ctrlStrb_t       strb,
  output logic [2*BW-1:0] dataReg,
  output logic [FW-1:0]   dutyLsb,
  output logic            intFlag
);
  localparam int PAD_W = BW - FW - MODE_W;

  logic [BW-1:0] dataLo, dataHi;
  logic [MODE_W-1:0] mode;
  logic [FW-1:0] dutyLsbReg;
  logic flagReg;
  logic wrLo, wrHi, wrCtl, wrFlag;
  logic unusedTopBits;

  assign wrLo = regWrEn && (regAddr == ADDR_LO);
  assign wrHi = regWrEn && (regAddr == ADDR_HI);
  assign wrCtl = regWrEn && (regAddr == ADDR_CTL);
  assign wrFlag = regWrEn && (regAddr == ADDR_FLAG);
  assign unusedTopBits = ^regWrData[BW-1:FW+MODE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataLo <= '0;
      dataHi <= '0;
      mode <= '0;
      dutyLsbReg <= '0;
      flagReg <= 1'b0;
    end else begin
      if (capStrobe) begin
        {dataHi, dataLo} <= capValue;
      end else begin
        if (wrLo) dataLo <= regWrData;
        if (wrHi) dataHi <= regWrData;
      end
      if (wrCtl) begin
        mode <= regWrData[MODE_W-1:0];
        dutyLsbReg <= regWrData[FW+MODE_W-1:MODE_W];
      end
      if (flagSet) flagReg <= 1'b1;
      else if (wrFlag) flagReg <= 1'b0;
    end
  end

  always_comb begin
    strb = '0;
    strb.off = (mode[3:2] == 2'b00);
    strb.capOn = (mode[3:2] == 2'b01);
    strb.capFall = (mode == 4'b0100);
    strb.capDiv = (mode[1:0] == 2'b11) ? CAPDIV_HIGH :
                  (mode[1:0] == 2'b10) ? CAPDIV_MID : CAPDIV_EACH;
    strb.cmpOn = (mode[3:2] == 2'b10);
    strb.cmpAct = cmpAct_e'(mode[1:0]);
    strb.pwmOn = (mode[3:2] == 2'b11);
    strb.modeChg = wrCtl && (regWrData[MODE_W-1:0] != mode);
  end

  always_comb begin
    case (regAddr)
      ADDR_LO:  regRdData = dataLo;
      ADDR_HI:  regRdData = dataHi;
      ADDR_CTL: regRdData = {{PAD_W{1'b0}}, dutyLsbReg, mode};
      default:  regRdData = {{(BW-1){1'b0}}, flagReg};
    endcase
  end

  assign dataReg = {dataHi, dataLo};
  assign dutyLsb = dutyLsbReg;
  assign intFlag = flagReg;

  AST_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |=> flagReg); // R2
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |=> ({dataHi, dataLo} == $past(capValue))); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg && !wrFlag) |=> flagReg); // R10
endmodule

// File: rtl/ccp_datapath.sv
module ccp_datapath
  import ccp_pkg::*;
#(
  parameter int CAP_W = DATA_W,
  parameter int PER_W = BYTE_W,
  parameter int FINE_W = FINE_BITS,
  parameter int DIV_A = PRESCALE_MID,
  parameter int DIV_B = PRESCALE_HIGH
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [CAP_W-1:0]  dataReg,
  input  logic [FINE_W-1:0] dutyLsb,
  input  logic [CAP_W-1:0]  tmrWide,
  input  logic [PER_W-1:0]  tmrNarrow,
  input  logic              pinIn,
  output logic              capStrobe,
  output logic [CAP_W-1:0]  capValue,
  output logic              flagSet,
  output logic              pinOut,
  output logic              evtPulse
);
  localparam int PRE_W = $clog2(DIV_B);
  localparam int CNT_W = PER_W + FINE_W;
  localparam logic [PRE_W-1:0] LIM_A = PRE_W'(DIV_A - 1);
  localparam logic [PRE_W-1:0] LIM_B = PRE_W'(DIV_B - 1);
  localparam logic [FINE_W-1:0] FINE_MAX = '1;

  // input synchronizer and edge detect
  logic [2:0] syncQ;
  logic pinRise, pinFall;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else syncQ <= {syncQ[1:0], pinIn};
  end

  assign pinRise = syncQ[1] && !syncQ[2];
  assign pinFall = !syncQ[1] && syncQ[2];

  // capture with edge divider
  logic [PRE_W-1:0] preCnt, preLimit;
  logic edgeHit, capFire;

  always_comb begin
    case (strb.capDiv)
      CAPDIV_MID:  preLimit = LIM_A;
      CAPDIV_HIGH: preLimit = LIM_B;
      default:     preLimit = '0;
    endcase
  end

  assign edgeHit = strb.capOn && (strb.capFall ? pinFall : pinRise);
  assign capFire = edgeHit && (preCnt == preLimit);

  always_ff @(posedge clk) begin
    if (!rstN || strb.off || strb.modeChg) preCnt <= '0;
    else if (edgeHit) preCnt <= capFire ? '0 : preCnt + 1'b1;
  end

  assign capStrobe = capFire;
  assign capValue = tmrWide;

  // compare
  logic cmpHit, hitOld, outLatch;

  assign cmpHit = strb.cmpOn && (tmrWide == dataReg);

  always_ff @(posedge clk) begin
    if (!rstN || strb.off) begin
      hitOld <= 1'b0;
      outLatch <= 1'b0;
      evtPulse <= 1'b0;
    end else begin
      hitOld <= cmpHit;
      evtPulse <= cmpHit && (strb.cmpAct == ACT_EVENT) && !hitOld;
      if (cmpHit && strb.cmpAct == ACT_SET) outLatch <= 1'b1;
      else if (cmpHit && strb.cmpAct == ACT_CLR) outLatch <= 1'b0;
    end
  end

  assign flagSet = capFire || cmpHit;

  // PWM
  logic [PER_W-1:0] narrowPrev;
  logic [FINE_W-1:0] fineReg, fineNow;
  logic [CNT_W-1:0] dutyBuf, dutyNew, dutyEff, countNow;
  logic narrowMoved, wrapNow, pwmHigh;

  assign narrowMoved = (tmrNarrow != narrowPrev);
  assign fineNow = narrowMoved ? '0 : fineReg;
  assign countNow = {tmrNarrow, fineNow};
  assign wrapNow = (tmrNarrow == '0) && (narrowPrev != '0);
  assign dutyNew = {dataReg[PER_W-1:0], dutyLsb};
  assign dutyEff = (strb.pwmOn && wrapNow) ? dutyNew : dutyBuf;
  assign pwmHigh = strb.pwmOn && (countNow < dutyEff);

  always_ff @(posedge clk) begin
    if (!rstN || strb.off) begin
      narrowPrev <= '0;
      fineReg <= '0;
      dutyBuf <= '0;
    end else begin
      narrowPrev <= tmrNarrow;
      if (narrowMoved) fineReg <= FINE_W'(1);
      else if (fineReg != FINE_MAX) fineReg <= fineReg + 1'b1;
      if (strb.pwmOn && wrapNow) dutyBuf <= dutyNew;
    end
  end

  assign pinOut = strb.pwmOn ? pwmHigh : (strb.cmpOn && outLatch);

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.off |=> (!outLatch && (preCnt == '0) && !evtPulse)); // R1
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse); // R6
  AST_EVT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> $past(strb.cmpOn && strb.cmpAct == ACT_EVENT)); // R11
  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.capOn |-> (preCnt <= preLimit)); // R3
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pwmOn && dutyEff == '0) |-> !pinOut); // R7
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic [DATA_W-1:0] tmrWide,
  input  logic [BYTE_W-1:0] tmrNarrow,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              intFlag,
  output logic              tmrResetPulse,
  output logic              adcStartPulse
);
  ctrlStrb_t strb;
  logic [DATA_W-1:0] dataReg, capValue;
  logic [FINE_BITS-1:0] dutyLsb;
  logic capStrobe, flagSet, evtPulse;

  ccp_ctrl #(.BW(BYTE_W), .FW(FINE_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .capStrobe(capStrobe),
    .capValue(capValue), .flagSet(flagSet), .strb(strb), .dataReg(dataReg),
    .dutyLsb(dutyLsb), .intFlag(intFlag)
  );

  ccp_datapath #(
    .CAP_W(DATA_W), .PER_W(BYTE_W), .FINE_W(FINE_BITS),
    .DIV_A(PRESCALE_MID), .DIV_B(PRESCALE_HIGH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dataReg(dataReg), .dutyLsb(dutyLsb),
    .tmrWide(tmrWide), .tmrNarrow(tmrNarrow), .pinIn(pinIn),
    .capStrobe(capStrobe), .capValue(capValue), .flagSet(flagSet),
    .pinOut(pinOut), .evtPulse(evtPulse)
  );

  assign tmrResetPulse = evtPulse;
  assign adcStartPulse = evtPulse;
endmodule

// File: tb/ccp_unit_tb_top.sv
module ccp_unit_tb_top;
  localparam int PER_STEPS = 10;
  localparam int STEP_CYC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic [15:0] tmrWide = 16'd0;
  logic [7:0] tmrNarrow = 8'd0;
  logic pinIn = 1'b0;
  logic pinOut, intFlag, tmrResetPulse, adcStartPulse;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ccp_unit dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tmrWide(tmrWide),
    .tmrNarrow(tmrNarrow), .pinIn(pinIn), .pinOut(pinOut), .intFlag(intFlag),
    .tmrResetPulse(tmrResetPulse), .adcStartPulse(adcStartPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrlReadback(input logic [7:0] w);
    return w & 8'h3F;
  endfunction

  function automatic logic pwmLevel(input int cnt, input int duty);
    return cnt < duty;
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic readData(output logic [15:0] v);
    logic [7:0] lo, hi;
    readReg(2'd0, lo);
    readReg(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic sample();
    @(negedge clk);
    #1;
  endtask

  task automatic pulsePin(input logic [15:0] v);
    tmrWide = v;
    pinIn = 1'b1;
    repeat (3) @(negedge clk);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runPwm(input int startDuty, input int newDuty, input int writeAt,
                        input int periods);
    logic [7:0] progLo;
    logic [1:0] progLsb;
    logic [1:0] modeLow;
    int effDuty, prevT, idx;
    logic [7:0] dummy;
    tmrNarrow = 8'd0;
    writeReg(2'd2, 8'h00);
    progLo = 8'(startDuty >> 2);
    progLsb = 2'(startDuty);
    modeLow = 2'($urandom);
    writeReg(2'd0, progLo);
    writeReg(2'd2, {2'b00, progLsb, 2'b11, modeLow});
    writeReg(2'd3, 8'h00);
    effDuty = 0;
    prevT = 0;
    idx = 0;
    for (int p = 0; p < periods; p++) begin
      for (int t = 0; t < PER_STEPS; t++) begin
        for (int s = 0; s < STEP_CYC; s++) begin
          @(negedge clk);
          tmrNarrow = 8'(t);
          regWrEn = 1'b0;
          if (idx == writeAt) begin
            regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'(newDuty >> 2);
          end else if (idx == writeAt + 1) begin
            regWrEn = 1'b1; regAddr = 2'd2; regWrData = {2'b00, 2'(newDuty), 2'b11, modeLow};
          end
          #1;
          if (t == 0 && prevT != 0) effDuty = {progLo, progLsb};
          check($sformatf("R7/R8 pwm period %0d count %0d duty %0d", p, t * STEP_CYC + s, effDuty),
                32'(pinOut), 32'(pwmLevel(t * STEP_CYC + s, effDuty)));
          if (idx == writeAt) progLo = 8'(newDuty >> 2);
          if (idx == writeAt + 1) progLsb = 2'(newDuty);
          prevT = t;
          idx++;
        end
      end
    end
    @(negedge clk);
    regWrEn = 1'b0;
    tmrNarrow = 8'd0;
    check("R7 pwm leaves flag clear", 32'(intFlag), 32'd0);
    readReg(2'd3, dummy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    logic [15:0] dv, v, dcmp;
    logic [31:0] r;
    int seedDummy;
    seedDummy = int'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: reset values
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), rv);
      check($sformatf("R9 reset value addr %0d", a), 32'(rv), 32'd0);
    end
    check("R1 pin low after reset", 32'(pinOut), 32'd0);
    check("R11 pulses low after reset", 32'({tmrResetPulse, adcStartPulse}), 32'd0);

    // R9: top control bits read zero
    writeReg(2'd2, 8'hFF);
    readReg(2'd2, rv);
    check("R9 control readback", 32'(rv), 32'(ctrlReadback(8'hFF)));
    writeReg(2'd2, 8'h00);
    readReg(2'd2, rv);
    check("R9 control cleared", 32'(rv), 32'd0);

    // R2: rising edge capture with latency
    writeReg(2'd2, 8'h05);
    tmrWide = 16'hBEEF;
    @(negedge clk);
    pinIn = 1'b1;
    sample();
    sample();
    check("R2 no capture one edge early", 32'(intFlag), 32'd0);
    sample();
    check("R2 flag at second edge", 32'(intFlag), 32'd1);
    check("R11 pin low in capture mode", 32'(pinOut), 32'd0);
    readData(dv);
    check("R2 rising capture value", 32'(dv), 32'hBEEF);
    writeReg(2'd3, 8'h00);
    check("R10 flag cleared by write", 32'(intFlag), 32'd0);
    tmrWide = 16'h1111;
    repeat (3) @(negedge clk);
    pinIn = 1'b0;
    repeat (4) @(negedge clk);
    readData(dv);
    check("R2 falling edge ignored in rising mode", 32'(dv), 32'hBEEF);
    check("R2 no flag on falling edge", 32'(intFlag), 32'd0);

    // R2: falling edge mode
    writeReg(2'd2, 8'h04);
    tmrWide = 16'h5A5A;
    pinIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 rising ignored in falling mode", 32'(intFlag), 32'd0);
    pinIn = 1'b0;
    repeat (4) @(negedge clk);
    readData(dv);
    check("R2 falling capture value", 32'(dv), 32'h5A5A);
    check("R2 falling capture flag", 32'(intFlag), 32'd1);

    // R3: every 4th rising edge
    writeReg(2'd2, 8'h06);
    writeReg(2'd3, 8'h00);
    for (int i = 1; i <= 4; i++) begin
      pulsePin(16'h1000 + 16'(i));
      if (i < 4) check($sformatf("R3 div4 no capture at edge %0d", i), 32'(intFlag), 32'd0);
    end
    readData(dv);
    check("R3 div4 captures 4th edge", 32'(dv), 32'h1004);
    check("R3 div4 flag", 32'(intFlag), 32'd1);

    // R3: every 16th rising edge, random values
    writeReg(2'd2, 8'h07);
    writeReg(2'd3, 8'h00);
    v = 16'h0;
    for (int i = 1; i <= 16; i++) begin
      v = 16'($urandom);
      pulsePin(v);
      if (i == 15) check("R3 div16 no capture at 15th edge", 32'(intFlag), 32'd0);
    end
    readData(dv);
    check("R3 div16 captures 16th edge", 32'(dv), 32'(v));
    check("R3 div16 flag", 32'(intFlag), 32'd1);

    // R3: mode change restarts the edge count
    writeReg(2'd2, 8'h06);
    writeReg(2'd3, 8'h00);
    pulsePin(16'h2001);
    pulsePin(16'h2002);
    writeReg(2'd2, 8'h07);
    writeReg(2'd2, 8'h06);
    pulsePin(16'h2003);
    pulsePin(16'h2004);
    pulsePin(16'h2005);
    check("R3 count restarted after mode change", 32'(intFlag), 32'd0);
    pulsePin(16'h2006);
    readData(dv);
    check("R3 capture after restart", 32'(dv), 32'h2006);

    // R4: compare set output, random misses then a match
    for (int k = 0; k < 4; k++) begin
      dcmp = (k == 0) ? 16'h1234 : 16'($urandom);
      writeReg(2'd2, 8'h00);
      check("R1 pin low when disabled", 32'(pinOut), 32'd0);
      writeReg(2'd0, dcmp[7:0]);
      writeReg(2'd1, dcmp[15:8]);
      writeReg(2'd3, 8'h00);
      writeReg(2'd2, 8'h08);
      for (int j = 0; j < 12; j++) begin
        r = $urandom;
        tmrWide = (r[15:0] == dcmp) ? ~dcmp : r[15:0];
        sample();
        check("R4 no action without match", 32'({pinOut, intFlag}), 32'd0);
      end
      tmrWide = dcmp;
      sample();
      check("R4 set on match", 32'(pinOut), 32'd1);
      check("R4 flag on set match", 32'(intFlag), 32'd1);
      check("R11 no pulse in set mode", 32'({tmrResetPulse, adcStartPulse}), 32'd0);
      tmrWide = ~dcmp;
      sample();
      sample();
      check("R4 output holds after match", 32'(pinOut), 32'd1);
    end

    // R4: clear on match
    writeReg(2'd2, 8'h09);
    check("R4 latch kept across compare modes", 32'(pinOut), 32'd1);
    writeReg(2'd3, 8'h00);
    tmrWide = dcmp;
    sample();
    check("R4 clear on match", 32'(pinOut), 32'd0);
    check("R4 flag on clear match", 32'(intFlag), 32'd1);
    tmrWide = ~dcmp;

    // R5: flag only
    writeReg(2'd2, 8'h08);
    tmrWide = dcmp;
    sample();
    tmrWide = ~dcmp;
    writeReg(2'd2, 8'h0A);
    writeReg(2'd3, 8'h00);
    tmrWide = dcmp;
    sample();
    check("R5 flag on match", 32'(intFlag), 32'd1);
    check("R5 pin unchanged high", 32'(pinOut), 32'd1);
    check("R11 no pulse in flag mode", 32'({tmrResetPulse, adcStartPulse}), 32'd0);
    tmrWide = ~dcmp;

    // R6: special event
    writeReg(2'd2, 8'h0B);
    writeReg(2'd3, 8'h00);
    tmrWide = dcmp;
    sample();
    check("R6 timer reset pulse", 32'(tmrResetPulse), 32'd1);
    check("R6 conversion start pulse", 32'(adcStartPulse), 32'd1);
    check("R6 flag on event match", 32'(intFlag), 32'd1);
    check("R6 pin unchanged", 32'(pinOut), 32'd1);
    sample();
    check("R6 pulse lasts one cycle", 32'({tmrResetPulse, adcStartPulse}), 32'd0);
    tmrWide = ~dcmp;
    sample();
    tmrWide = dcmp;
    sample();
    check("R6 pulse on new match", 32'(tmrResetPulse), 32'd1);
    tmrWide = ~dcmp;

    // R1: disable clears the output latch
    writeReg(2'd2, 8'h00);
    check("R1 pin low in disabled mode", 32'(pinOut), 32'd0);
    writeReg(2'd2, 8'h03);
    writeReg(2'd2, 8'h08);
    check("R1 latch cleared by disable", 32'(pinOut), 32'd0);
    check("R1 no pulse after disable", 32'({tmrResetPulse, adcStartPulse}), 32'd0);

    // R7, R8: PWM, directed then random
    runPwm(13, 30, 55, 3);
    runPwm(0, 45, 50, 3);
    runPwm(40, 1, 45, 3);
    for (int k = 0; k < 4; k++) begin
      runPwm(int'($urandom % 48), int'($urandom % 48), 40 + int'($urandom % 20), 3);
    end

    // R9: random control readback
    for (int k = 0; k < 4; k++) begin
      r = $urandom;
      writeReg(2'd2, r[7:0]);
      readReg(2'd2, rv);
      check("R9 control readback random", 32'(rv), 32'(ctrlReadback(r[7:0])));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule